// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds a small bank of free-running counters that measure activity inside a cache pipeline. Each cycle the pipeline presents a vector of one-cycle event strobes. Every counter has its own configuration word. The word chooses which strobe that counter follows and whether a software read also clears the count. On each cycle in which its chosen event fires, the counter adds one. Event code 0 is special: it stands for the clock itself, so a counter set to code 0 counts cycles.

Software programs a counter by writing its configuration word through a plain write strobe. It samples a counter by pulsing a read strobe with the counter index. The value comes back one cycle later, marked by a valid flag. Neither port has back-pressure. A read request is always accepted, and its result is presented for exactly one cycle. Changing a counter's configuration never disturbs the value it has already accumulated. This lets software switch an event on the fly and keep a running total.

Top module: `pcb_bank`

## Requirements
- R1: After reset every counter reads zero, and every event select resets to code 63. That code counts nothing, so the counts stay zero until software configures a counter.
- R2: A counter whose select field holds a code from 1 to NUM_EVT-1 adds one at each clock edge where `evt_i` bit [code] is high. The count only increases in the way R4, R8 and R9 allow.
- R3: A counter with select code 0 adds one on every clock cycle, whatever the value of `evt_i`.
- R4: When a counter's clear-on-read bit is set, a read returns the current count and leaves the counter at zero, or at one if the event also fires in that cycle.
- R5: When a counter's clear-on-read bit is clear, a read returns the count and leaves the count unchanged.
- R6: A configuration write changes no count. A counter whose new select code counts nothing keeps exactly the value it held before the write.
- R7: A select code of NUM_EVT (54) or above counts nothing. Select codes sit in configuration bits 5:0, and clear-on-read sits in bit 8. All other bits of `cfg_wdata` are ignored.
- R8: If a clearing read and an increment fall in the same cycle, the read returns the old value and the counter holds 1 afterwards.
- R9: A counter that is all ones and increments wraps to zero. There is no saturation.
- R10: `rd_valid` is high exactly in the cycle after `rd_en`, and `rd_data` in that cycle carries the count as it stood at the edge where the read was taken.
- R11: The NUM_CTR counters (four by default, indexed 0 to 3) are independent. A write or read aimed at one index affects no other counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event strobes; bit 0 is unused (code 0 means cycles) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NUM_CTR) | Counter targeted by the write |
| cfg_wdata | input | 16 | Configuration word: select in 5:0, clear-on-read in 8 |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | $clog2(NUM_CTR) | Counter to read |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_data | output | CTR_W | Count returned by the read |

## Verification
The bench builds the bank with CTR_W set to 8 and keeps the default four counters and 54 event codes. With 8-bit counters, wraparound is reached by counting cycles for a few hundred clocks, which would be impossible at 64 bits. All select codes, including the idle codes 54 to 63, remain in reach. Random configuration writes and reads are mixed with random event vectors. This makes clearing reads that coincide with increments, and writes that land on a counting counter, occur many times over.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int SEL_W   = 6;
  localparam int SEL_LSB = 0;
  localparam int COR_BIT = 8;
  localparam int CFG_W   = 16;

  typedef struct packed {
    logic             cor;
    logic [SEL_W-1:0] sel;
  } ctr_cfg_t;

  localparam ctr_cfg_t CFG_RESET = '{cor: 1'b0, sel: {SEL_W{1'b1}}};

  function automatic ctr_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    ctr_cfg_t c;
    c.sel = w[SEL_LSB +: SEL_W];
    c.cor = w[COR_BIT];
    return c;
  endfunction
endpackage

// File: rtl/pcb_evt_sel.sv
module pcb_evt_sel
  import pcb_pkg::*;
#(
  parameter int NUM_EVT = 54
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    if (sel_i == '0) begin
      hit_o = 1'b1;
    end else begin
      for (int e = 1; e < NUM_EVT; e++) begin
        if (int'(sel_i) == e) hit_o = evt_i[e];
      end
    end
  end
endmodule

// File: rtl/pcb_ctr.sv
module pcb_ctr #(
  parameter int CTR_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             clr_i,
  output logic [CTR_W-1:0] cnt_o
);
  logic [CTR_W-1:0] base;

  assign base = clr_i ? '0 : cnt_o;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= base + CTR_W'(hit_i);
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !clr_i) |=> cnt_o == $past(cnt_o) + CTR_W'(1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && !clr_i) |=> $stable(cnt_o)); // R6
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_o == CTR_W'($past(hit_i))); // R8
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_o) && hit_i && !clr_i) |=> cnt_o == '0); // R9
endmodule

// File: rtl/pcb_bank.sv
module pcb_bank
  import pcb_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int NUM_EVT = 54,
  parameter int CTR_W   = 64,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [CTR_W-1:0]   rd_data
);
  ctr_cfg_t         cfg_q [NUM_CTR];
  logic [CTR_W-1:0] cnt   [NUM_CTR];
  logic [NUM_CTR-1:0] hit;
  logic [NUM_CTR-1:0] clr;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n)                                    cfg_q[k] <= CFG_RESET;
      else if (cfg_we && cfg_idx == IDX_W'(k))       cfg_q[k] <= decode_cfg(cfg_wdata);
    end

    assign clr[k] = rd_en && (rd_idx == IDX_W'(k)) && cfg_q[k].cor;

    pcb_evt_sel #(.NUM_EVT(NUM_EVT)) u_sel (
      .sel_i (cfg_q[k].sel),
      .evt_i (evt_i),
      .hit_o (hit[k])
    );

    pcb_ctr #(.CTR_W(CTR_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (hit[k]),
      .clr_i (clr[k]),
      .cnt_o (cnt[k])
    );

    AST_CYCLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[k].sel == '0) |-> hit[k]); // R3
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_q[k].sel) >= NUM_EVT) |-> !hit[k]); // R7
    AST_NO_CLEAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_idx == IDX_W'(k) && !cfg_q[k].cor && !hit[k]) |=> $stable(cnt[k])); // R5
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= cnt[rd_idx];
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R10
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R10
  AST_CLEAR_TARGETED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr)); // R11
endmodule

// File: tb/pcb_bank_tb_top.sv
`timescale 1ns/1ps
module pcb_bank_tb_top;
  localparam int NUM_CTR = 4;
  localparam int NUM_EVT = 54;
  localparam int CTR_W   = 8;
  localparam int IDX_W   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EVT-1:0] evt_i = '0;
  logic               cfg_we = 1'b0;
  logic [IDX_W-1:0]   cfg_idx = '0;
  logic [15:0]        cfg_wdata = '0;
  logic               rd_en = 1'b0;
  logic [IDX_W-1:0]   rd_idx = '0;
  logic               rd_valid;
  logic [CTR_W-1:0]   rd_data;

  always #2.5 clk = ~clk;

  pcb_bank #(.NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT), .CTR_W(CTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string tag = "R1";

  logic [CTR_W-1:0] m_cnt [NUM_CTR];
  logic [5:0]       m_sel [NUM_CTR];
  logic             m_cor [NUM_CTR];

  function automatic bit model_hit(input logic [5:0] s, input logic [NUM_EVT-1:0] ev);
    if (s == 0) return 1'b1;
    if (int'(s) >= NUM_EVT) return 1'b0;
    return ev[s];
  endfunction

  task automatic check(input string rq, input logic [CTR_W-1:0] act, input logic [CTR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NUM_CTR; k++) begin
      m_cnt[k] = '0; m_sel[k] = 6'h3f; m_cor[k] = 1'b0;
    end
  endtask

  // one cycle: drive at negedge, apply model, check at the following negedge
  task automatic step(input bit we, input int widx, input logic [15:0] wd,
                      input bit re, input int ridx, input logic [NUM_EVT-1:0] ev);
    logic [CTR_W-1:0] exp_rd;
    cfg_we = we; cfg_idx = IDX_W'(widx); cfg_wdata = wd;
    rd_en = re; rd_idx = IDX_W'(ridx); evt_i = ev;
    exp_rd = m_cnt[ridx];
    for (int k = 0; k < NUM_CTR; k++) begin
      logic [CTR_W-1:0] b;
      b = (re && ridx == k && m_cor[k]) ? '0 : m_cnt[k];
      m_cnt[k] = b + CTR_W'(model_hit(m_sel[k], ev));
    end
    if (we) begin
      m_sel[widx] = wd[5:0];
      m_cor[widx] = wd[8];
    end
    @(posedge clk);
    @(negedge clk);
    check("R10", CTR_W'(rd_valid), CTR_W'(re));
    if (re) check(tag, rd_data, exp_rd);
    cfg_we = 1'b0; rd_en = 1'b0;
  endtask

  task automatic idle(input int n, input logic [NUM_EVT-1:0] ev);
    for (int i = 0; i < n; i++) step(0, 0, 16'h0, 0, 0, ev);
  endtask

  function automatic logic [15:0] cw(input int sel, input bit cor);
    return 16'(sel & 63) | (cor ? 16'h0100 : 16'h0000) | 16'hf600;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    idle(5, {NUM_EVT{1'b1}});
    for (int k = 0; k < NUM_CTR; k++) step(0, 0, 0, 1, k, '0);

    tag = "R3";
    step(1, 0, cw(0, 0), 0, 0, '0);
    idle(20, '0);
    step(0, 0, 0, 1, 0, '0);
    tag = "R5";
    step(0, 0, 0, 1, 0, '0);

    tag = "R2";
    step(1, 1, cw(5, 1), 0, 0, '0);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, (i % 3 == 0) ? (NUM_EVT'(1) << 5) : ~(NUM_EVT'(1) << 5));
    step(0, 0, 0, 1, 1, '0);
    tag = "R4";
    step(0, 0, 0, 1, 1, '0);

    tag = "R7";
    step(1, 2, cw(60, 0), 0, 0, '0);
    step(1, 2, cw(54, 0), 0, 0, {NUM_EVT{1'b1}});
    idle(10, {NUM_EVT{1'b1}});
    step(0, 0, 0, 1, 2, {NUM_EVT{1'b1}});

    tag = "R6";
    step(1, 0, cw(63, 0), 0, 0, '0);
    idle(4, {NUM_EVT{1'b1}});
    step(0, 0, 0, 1, 0, '0);
    step(1, 0, cw(7, 1), 0, 0, '0);
    step(0, 0, 0, 1, 0, '0);

    tag = "R8";
    step(1, 3, cw(0, 1), 0, 0, '0);
    idle(6, '0);
    step(0, 0, 0, 1, 3, '0);
    step(0, 0, 0, 1, 3, '0);

    tag = "R9";
    step(1, 0, cw(0, 0), 0, 0, '0);
    idle(300, '0);
    step(0, 0, 0, 1, 0, '0);

    tag = "R11";
    step(1, 1, cw(10, 0), 0, 0, '0);
    step(1, 2, cw(20, 0), 0, 0, '0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, {$urandom, $urandom});
    for (int k = 0; k < NUM_CTR; k++) step(0, 0, 0, 1, k, '0);

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      bit we, re;
      we = ($urandom % 8) == 0;
      re = ($urandom % 3) == 0;
      step(we, int'($urandom % NUM_CTR), 16'($urandom), re, int'($urandom % NUM_CTR),
           {$urandom, $urandom});
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule